// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the I/O-mapped configuration front end of a multi-function peripheral chip on an ISA-style bus. It watches one relocatable base address for a one-byte unlock key. After the key is written, the block exposes an index/data register pair that reads and writes a small internal array of configuration registers. A second key locks the registers again. Outside configuration mode the index and data ports do not respond at all, so the configuration space uses no visible I/O decode during normal operation.

A strap input is sampled for as long as reset is held. The value present when reset is released picks the default base address. Two registers in the array hold the base address, so firmware can move the port anywhere in the 16-bit I/O space. One further register drives the enable bits of the logical devices that the chip hosts. Reset is synchronous and active high. All bus strobes are single-cycle and are sampled on the rising clock edge. Read data is combinational and is valid for the cycle that the read strobe is high.

Top module: `kcp_top`

## Requirements
- R1: While reset is held and on the first cycle after it is released, the block is in run mode (`cfg_mode_o`=0), all `dev_en_o` bits are 0, the index register is 0x00 and `io_oe_o` is 0.
- R2: In run mode, a write of 0x55 to the base address enters configuration mode, with `cfg_mode_o`=1 from the next cycle.
- R3: In configuration mode, a write of 0xAA to the base address returns the block to run mode. Afterwards, index and data port reads leave `io_oe_o` low.
- R4: The strap level present when reset is released sets the default base: 0 gives 0x03F0 and 1 gives 0x0370. The block ignores changes to the strap after reset and ignores accesses to the address the strap did not select.
- R5: In configuration mode, a read at the base address returns the index register. A write or read at base+1 accesses the register selected by the index. Written values read back unchanged.
- R6: In run mode, index and data port writes do not change any register, and data port reads leave `io_oe_o` low.
- R7: Register 0x26 holds the base address low byte and register 0x27 holds the high byte. Both read back the current base. A write to either one moves the decode from the very next bus cycle.
- R8: When `aen_i` is 1, no access is decoded: no mode change, no register write and `io_oe_o`=0.
- R9: The base address is write-only in run mode: a read there leaves `io_oe_o` low. `io_oe_o` is 1 only during a decoded configuration-mode read.
- R10: In configuration mode, a write to the base address of any value other than 0xAA (0x55 included) loads that value into the index register and leaves the mode unchanged.
- R11: `dev_en_o` equals the low NDEV bits of register 0x30.
- R12: Indices at or above the register file depth (64) read as 0x00 with `io_oe_o`=1. Writes to those indices are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| strap_i | input | 1 | Base-select strap, sampled while reset is held |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Single-cycle write strobe |
| io_rd_i | input | 1 | Read strobe |
| aen_i | input | 1 | Address enable; high blocks all decoding |
| io_rdata_o | output | 8 | Read data |
| io_oe_o | output | 1 | Read data drive enable |
| cfg_mode_o | output | 1 | 1 while in configuration mode |
| dev_en_o | output | 8 | Logical device enable bits |

## Verification
The hardest situation to reach is the middle of a base relocation. After the high byte is written but before the low byte is written, the port sits at a mixed address. The next access has to land there, and any access to the old or final address must be ignored. The bench changes the two bytes one at a time and computes each intermediate address itself. A second reset with the opposite strap level confirms that a later strap change is ignored. It also confirms that the other default address never responds.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
    typedef enum logic {
        MODE_RUN = 1'b0,
        MODE_CFG = 1'b1
    } kcp_mode_e;

    localparam logic [7:0]  KEY_UNLOCK = 8'h55;
    localparam logic [7:0]  KEY_LOCK   = 8'hAA;
    localparam logic [15:0] BASE_STRAP0 = 16'h03F0;
    localparam logic [15:0] BASE_STRAP1 = 16'h0370;
    localparam int unsigned IDX_BASE_LO = 8'h26;
    localparam int unsigned IDX_BASE_HI = 8'h27;
    localparam int unsigned IDX_DEV_EN  = 8'h30;
endpackage

// File: rtl/kcp_decode.sv
module kcp_decode #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] io_addr_i,
    input  logic [AW-1:0] base_i,
    input  logic          aen_i,
    input  logic          io_wr_i,
    input  logic          io_rd_i,
    output logic          idx_wr_o,
    output logic          idx_rd_o,
    output logic          dat_wr_o,
    output logic          dat_rd_o
);
    logic [AW-1:0] data_addr;
    logic          at_base;
    logic          at_data;

    always_comb begin
        data_addr = base_i + AW'(1);
        at_base   = !aen_i && (io_addr_i == base_i);
        at_data   = !aen_i && (io_addr_i == data_addr);
        idx_wr_o  = at_base && io_wr_i;
        idx_rd_o  = at_base && io_rd_i;
        dat_wr_o  = at_data && io_wr_i;
        dat_rd_o  = at_data && io_rd_i;
    end
endmodule

// File: rtl/kcp_mode_fsm.sv
module kcp_mode_fsm
    import kcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       port_wr_i,
    input  logic [7:0] wdata_i,
    output kcp_mode_e  mode_o,
    output logic [7:0] index_o
);
    typedef struct packed {
        kcp_mode_e  mode;
        logic [7:0] index;
    } fsm_state_t;

    fsm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (port_wr_i) begin
            unique case (st_q.mode)
                MODE_RUN: begin
                    if (wdata_i == KEY_UNLOCK) st_d.mode = MODE_CFG;
                end
                MODE_CFG: begin
                    if (wdata_i == KEY_LOCK) st_d.mode  = MODE_RUN;
                    else                     st_d.index = wdata_i;
                end
                default: st_d.mode = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode  <= MODE_RUN;
            st_q.index <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign index_o = st_q.index;

    p_enter_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_RUN && port_wr_i && wdata_i == KEY_UNLOCK) |=> (mode_o == MODE_CFG));

    p_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_CFG && port_wr_i && wdata_i == KEY_LOCK) |=> (mode_o == MODE_RUN));

    p_index_load_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_CFG && port_wr_i && wdata_i != KEY_LOCK)
            |=> (mode_o == MODE_CFG && index_o == $past(wdata_i)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !port_wr_i |=> ($stable(mode_o) && $stable(index_o)));
endmodule

// File: rtl/kcp_regfile.sv
module kcp_regfile
    import kcp_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned NDEV  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strap_i,
    input  logic            wr_en_i,
    input  logic [7:0]      idx_i,
    input  logic [7:0]      wdata_i,
    output logic [7:0]      rdata_o,
    output logic [15:0]     base_o,
    output logic [NDEV-1:0] dev_en_o
);
    localparam int unsigned IW = $clog2(DEPTH);

    typedef struct {
        logic [7:0] r [DEPTH];
    } rf_state_t;

    rf_state_t rf_d, rf_q;
    logic      in_range;
    logic [15:0] strap_base;

    always_comb begin
        in_range   = (32'(idx_i) < DEPTH);
        strap_base = strap_i ? BASE_STRAP1 : BASE_STRAP0;
        rf_d       = rf_q;
        if (wr_en_i && in_range) begin
            rf_d.r[idx_i[IW-1:0]] = wdata_i;
        end
        rdata_o = in_range ? rf_q.r[idx_i[IW-1:0]] : 8'h00;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                if (g == IDX_BASE_LO)      rf_q.r[g] <= strap_base[7:0];
                else if (g == IDX_BASE_HI) rf_q.r[g] <= strap_base[15:8];
                else                       rf_q.r[g] <= 8'h00;
            end else begin
                rf_q.r[g] <= rf_d.r[g];
            end
        end
    end

    assign base_o   = {rf_q.r[IDX_BASE_HI], rf_q.r[IDX_BASE_LO]};
    assign dev_en_o = rf_q.r[IDX_DEV_EN][NDEV-1:0];

    p_strap_base_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (base_o == ($past(strap_i) ? BASE_STRAP1 : BASE_STRAP0)));

    p_dev_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> ($stable(dev_en_o) && $stable(base_o)));

    p_wide_drop_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && idx_i >= 8'(DEPTH)) |=> ($stable(dev_en_o) && $stable(base_o)));
endmodule

// File: rtl/kcp_top.sv
module kcp_top
    import kcp_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned NDEV  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strap_i,
    input  logic [15:0]     io_addr_i,
    input  logic [7:0]      io_wdata_i,
    input  logic            io_wr_i,
    input  logic            io_rd_i,
    input  logic            aen_i,
    output logic [7:0]      io_rdata_o,
    output logic            io_oe_o,
    output logic            cfg_mode_o,
    output logic [NDEV-1:0] dev_en_o
);
    logic [15:0] base;
    logic        idx_wr, idx_rd, dat_wr, dat_rd;
    kcp_mode_e   mode;
    logic [7:0]  index;
    logic [7:0]  reg_rdata;
    logic        in_cfg;

    kcp_decode #(.AW(16)) u_dec (
        .io_addr_i (io_addr_i),
        .base_i    (base),
        .aen_i     (aen_i),
        .io_wr_i   (io_wr_i),
        .io_rd_i   (io_rd_i),
        .idx_wr_o  (idx_wr),
        .idx_rd_o  (idx_rd),
        .dat_wr_o  (dat_wr),
        .dat_rd_o  (dat_rd)
    );

    kcp_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .port_wr_i (idx_wr),
        .wdata_i   (io_wdata_i),
        .mode_o    (mode),
        .index_o   (index)
    );

    assign in_cfg = (mode == MODE_CFG);

    kcp_regfile #(.DEPTH(DEPTH), .NDEV(NDEV)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .strap_i  (strap_i),
        .wr_en_i  (dat_wr && in_cfg),
        .idx_i    (index),
        .wdata_i  (io_wdata_i),
        .rdata_o  (reg_rdata),
        .base_o   (base),
        .dev_en_o (dev_en_o)
    );

    always_comb begin
        io_oe_o    = in_cfg && (idx_rd || dat_rd) && !rst;
        io_rdata_o = 8'h00;
        if (io_oe_o) io_rdata_o = idx_rd ? index : reg_rdata;
    end

    assign cfg_mode_o = in_cfg;

    p_oe_read_only_r9: assert property (@(posedge clk) disable iff (rst)
        io_oe_o |-> (io_rd_i && cfg_mode_o));

    p_aen_block_r8: assert property (@(posedge clk) disable iff (rst)
        aen_i |-> (!io_oe_o));

    p_aen_mode_r8: assert property (@(posedge clk) disable iff (rst)
        aen_i |=> $stable(cfg_mode_o));

    p_run_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode_o |=> $stable(dev_en_o));
endmodule

// File: tb/kcp_top_bench.sv
module kcp_top_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        strap_i = 0;
    logic [15:0] io_addr_i = 0;
    logic [7:0]  io_wdata_i = 0;
    logic        io_wr_i = 0, io_rd_i = 0, aen_i = 0;
    logic [7:0]  io_rdata_o;
    logic        io_oe_o, cfg_mode_o;
    logic [7:0]  dev_en_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    kcp_top u_kcp_top (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, logic en_block = 0);
        @(negedge clk);
        io_addr_i = a; io_wdata_i = d; io_wr_i = 1; aen_i = en_block;
        @(negedge clk);
        io_wr_i = 0; aen_i = 0;
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        io_addr_i = a; io_rd_i = 1;
        #2;
        d = io_rdata_o; oe = io_oe_o;
        @(negedge clk);
        io_rd_i = 0;
    endtask

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    task automatic do_reset(logic s);
        rst = 1; strap_i = s;
        repeat (4) @(negedge clk);
        rst = 0;
        #2;
        strap_i = ~s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic oe;
        do_reset(0);
        check("R1 mode", cfg_mode_o, 0);
        check("R1 dev_en", dev_en_o, 0);
        check("R1 oe", io_oe_o, 0);
        rd(16'h03F0, d, oe); check("R9 run read oe", oe, 0);
        wr(16'h03F1, 8'h12);
        rd(16'h03F1, d, oe); check("R6 run data read oe", oe, 0);
        wr(16'h03F0, 8'h55, 1); check("R8 aen blocks key", cfg_mode_o, 0);
        wr(16'h0370, 8'h55); check("R4 other base ignored", cfg_mode_o, 0);
        wr(16'h03F0, 8'h55); check("R2 enter", cfg_mode_o, 1);
        rd(16'h03F0, d, oe); check("R1 index reset", d, 0); check("R9 oe cfg", oe, 1);
        rd(16'h03F1, d, oe); check("R6 run write dropped", d, 0);
        rd(16'h03F0, d, oe) ; check("R8 pre", d, 0);
        @(negedge clk); io_addr_i = 16'h03F0; io_rd_i = 1; aen_i = 1; #2;
        check("R8 aen read oe", io_oe_o, 0);
        @(negedge clk); io_rd_i = 0; aen_i = 0;
        wr(16'h03F0, 8'h26); rd(16'h03F0, d, oe); check("R5 index readback", d, 8'h26);
        rd(16'h03F1, d, oe); check("R4 R7 base lo strap0", d, 8'hF0);
        wr(16'h03F0, 8'h27); rd(16'h03F1, d, oe); check("R7 base hi", d, 8'h03);
        wr(16'h03F0, 8'h55); check("R10 key as index mode", cfg_mode_o, 1);
        rd(16'h03F0, d, oe); check("R10 key as index", d, 8'h55);
        wr(16'h03F0, 8'h07); wr(16'h03F1, 8'hC3, 1);
        rd(16'h03F1, d, oe); check("R8 aen blocks data write", d, 0);
        for (int i = 0; i < 64; i++) begin
            if (i == 8'h26 || i == 8'h27) continue;
            wr(16'h03F0, 8'(i)); wr(16'h03F1, pat(i));
        end
        for (int i = 0; i < 64; i++) begin
            if (i == 8'h26 || i == 8'h27) continue;
            wr(16'h03F0, 8'(i)); rd(16'h03F1, d, oe);
            check("R5 sweep", {i[7:0], d}, {i[7:0], pat(i)});
        end
        check("R11 dev_en", dev_en_o, pat(8'h30));
        for (int i = 64; i < 256; i++) begin
            if (i == 8'hAA) continue;
            wr(16'h03F0, 8'(i)); wr(16'h03F1, 8'hFF); rd(16'h03F1, d, oe);
            check("R12 out of range", {i[7:0], oe, d}, {i[7:0], 1'b1, 8'h00});
        end
        check("R12 no alias", dev_en_o, pat(8'h30));
        wr(16'h03F0, 8'h27); wr(16'h03F1, 8'h02);
        rd(16'h03F0, d, oe); check("R7 old base dead", oe, 0);
        rd(16'h02F0, d, oe); check("R7 mid base", {oe, d}, {1'b1, 8'h27});
        wr(16'h02F0, 8'h26); wr(16'h02F1, 8'hE0);
        rd(16'h02F0, d, oe); check("R7 mid base dead", oe, 0);
        rd(16'h02E0, d, oe); check("R7 new base", {oe, d}, {1'b1, 8'h26});
        rd(16'h02E1, d, oe); check("R7 lo readback", d, 8'hE0);
        wr(16'h02E0, 8'hAA); check("R3 exit", cfg_mode_o, 0);
        rd(16'h02E1, d, oe); check("R3 data locked", oe, 0);
        rd(16'h02E0, d, oe); check("R3 index locked", oe, 0);
        do_reset(1);
        check("R1 dev_en after reset", dev_en_o, 0);
        check("R1 mode after reset", cfg_mode_o, 0);
        wr(16'h03F0, 8'h55); check("R4 strap1 ignores 3F0", cfg_mode_o, 0);
        wr(16'h0370, 8'h55); check("R4 strap1 enter", cfg_mode_o, 1);
        wr(16'h0370, 8'h26); rd(16'h0371, d, oe); check("R4 strap1 lo", d, 8'h70);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule